// File: doc/BRIEF.md
# Power-Up Strap Capture Sequencer

This block runs the power-up configuration phase of four pins that do two jobs. They are configuration inputs while the supply settles and clock outputs for the rest of the power cycle. Once the supply-good indication rises, the block counts a settling window of reference-clock cycles. Throughout that window it keeps the pin drivers disabled, so that external pull resistors set the pin levels. At the end of the window it captures the four levels and then turns the drivers on. A done flag rises with the driver enables, and downstream clock gating holds the outputs low until it does.

Three of the captured bits form a hardware frequency-select code. The fourth is a mode bit that decides what a neighbouring pin does. A software configuration byte can replace the captured code. The block chooses between the two codes and decodes the result into the CPU frequency, the PCI divide ratio and the spread type.

Top module: `strap_seq`

## Requirements
- R1: After `supply_ok` rises, `done` and every `pad_oe` bit stay low for exactly `WIN_CYCLES` rising clock edges. All five rise together on the `WIN_CYCLES`-th edge and stay high while `supply_ok` stays high.
- R2: On the edge where `done` rises, the block captures `strap_pin_i`. Bit 0 becomes FS0, bit 1 becomes FS1 and bit 2 becomes FS2 (`strap_fs[2:0]`), and bit 3 becomes `strap_mode`. Pin levels before that edge have no effect on the captured values.
- R3: Once `done` is high, changes to `strap_pin_i` or `cfg_byte0` leave `strap_fs` and `strap_mode` unchanged.
- R4: When `supply_ok` goes low, the block clears `done`, `pad_oe`, `strap_fs` and `strap_mode` at once. When `supply_ok` drops partway through the window, the count starts again from zero the next time it rises.
- R5: When `cfg_byte0` bit 3 is 0, `eff_code` equals `strap_fs`. When bit 3 is 1, `eff_code` equals `cfg_byte0[6:4]`. The change shows in the same cycle.
- R6: `cpu_freq_x10` gives the CPU frequency in units of 0.1 MHz:
  - code 000 gives 1240;
  - codes 001 and 011 give 668;
  - code 010 gives 833;
  - code 100 gives 1030;
  - codes 101 and 111 give 1000;
  - code 110 is reserved: it gives 0 and sets `code_rsvd`.
- R7: `pci_div3` is 1 for codes 000, 100, 101 and 111 (PCI = CPU/3) and 0 for all other codes. `center_spread` is 1 for codes 001 and 101 and 0 for all other codes (down spread).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_ok | input | 1 | Supply-good indication, active high; low means power is off |
| strap_pin_i | input | 4 | Pad levels: [2:0] frequency select, [3] mode |
| cfg_byte0 | input | 8 | Software byte: [3] software select, [6:4] software code |
| pad_oe | output | 4 | Driver enables of the four pins |
| done | output | 1 | Capture complete, drivers on |
| strap_fs | output | 3 | Captured frequency-select bits |
| strap_mode | output | 1 | Captured mode bit |
| eff_code | output | 3 | Effective frequency code |
| cpu_freq_x10 | output | 11 | CPU frequency in 0.1 MHz |
| pci_div3 | output | 1 | PCI ratio is CPU/3 (else CPU/2) |
| center_spread | output | 1 | Center spread (else down spread) |
| code_rsvd | output | 1 | Effective code is reserved |

## Verification
The hardest case to reach from the ports is `supply_ok` dropping inside the window. A count that is not cleared would then end the next window early. The stimulus aborts a window partway through, raises `supply_ok` again, and checks the edge count from the new rise. It also changes the pin levels one edge before the capture edge and again right after it. This shows that only the level on the capture edge is kept. Random power cycles with random pin patterns follow, and random configuration bytes drive both paths of the select.

// File: rtl/strap_seq.sv
module strap_seq #(
  parameter int unsigned WIN_CYCLES = 28636
) (
  input  logic        clk,
  input  logic        supply_ok,
  input  logic [3:0]  strap_pin_i,
  input  logic [7:0]  cfg_byte0,
  output logic [3:0]  pad_oe,
  output logic        done,
  output logic [2:0]  strap_fs,
  output logic        strap_mode,
  output logic [2:0]  eff_code,
  output logic [10:0] cpu_freq_x10,
  output logic        pci_div3,
  output logic        center_spread,
  output logic        code_rsvd
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      cnt        <= '0;
      done       <= 1'b0;
      strap_fs   <= 3'b000;
      strap_mode <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) begin
        done                  <= 1'b1;
        {strap_mode, strap_fs} <= strap_pin_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pad_oe   = {4{done}};
  assign eff_code = cfg_byte0[3] ? cfg_byte0[6:4] : strap_fs;

  always_comb begin
    cpu_freq_x10  = 11'd0;
    pci_div3      = 1'b0;
    center_spread = 1'b0;
    code_rsvd     = 1'b0;
    case (eff_code)
      3'b000: begin cpu_freq_x10 = 11'd1240; pci_div3 = 1'b1; end
      3'b001: begin cpu_freq_x10 = 11'd668;  center_spread = 1'b1; end
      3'b010: cpu_freq_x10 = 11'd833;
      3'b011: cpu_freq_x10 = 11'd668;
      3'b100: begin cpu_freq_x10 = 11'd1030; pci_div3 = 1'b1; end
      3'b101: begin cpu_freq_x10 = 11'd1000; pci_div3 = 1'b1; center_spread = 1'b1; end
      3'b110: code_rsvd = 1'b1;
      default: begin cpu_freq_x10 = 11'd1000; pci_div3 = 1'b1; end
    endcase
  end
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int unsigned WIN_CYCLES = 28636
) (
  input logic        clk,
  input logic        supply_ok,
  input logic [3:0]  strap_pin_i,
  input logic [3:0]  pad_oe,
  input logic        done,
  input logic [2:0]  strap_fs,
  input logic        strap_mode,
  input logic [10:0] cpu_freq_x10,
  input logic        center_spread
);
  int unsigned since_up;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) since_up <= 0;
    else if (!done) since_up <= since_up + 1;
  end

  // R1: the drivers turn on exactly when the window ends
  a_r1_window_end: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(done) |-> since_up == WIN_CYCLES);
  a_r1_not_late: assert property (@(posedge clk) disable iff (!supply_ok)
    since_up == WIN_CYCLES |-> done);
  a_r1_stays_on: assert property (@(posedge clk) disable iff (!supply_ok)
    done |=> (done && pad_oe == 4'hF));
  // R2
  a_r2_capture: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(done) |-> {strap_mode, strap_fs} == $past(strap_pin_i));
  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (!supply_ok)
    (done && $past(done)) |-> $stable({strap_mode, strap_fs}));
  // R4
  a_r4_off_before: assert property (@(posedge clk) disable iff (!supply_ok)
    !done |-> (pad_oe == 4'h0 && strap_fs == 3'b000 && !strap_mode));
  // R7
  a_r7_center: assert property (@(posedge clk) disable iff (!supply_ok)
    center_spread |-> (cpu_freq_x10 == 11'd668 || cpu_freq_x10 == 11'd1000));
endmodule

bind strap_seq strap_seq_chk #(.WIN_CYCLES(WIN_CYCLES)) chk_i (
  .clk(clk), .supply_ok(supply_ok), .strap_pin_i(strap_pin_i), .pad_oe(pad_oe),
  .done(done), .strap_fs(strap_fs), .strap_mode(strap_mode),
  .cpu_freq_x10(cpu_freq_x10), .center_spread(center_spread));

// File: tb/strap_seq_tb.sv
module strap_seq_tb_top;
  localparam int unsigned WIN = 40;

  logic clk = 1'b0;
  logic supply_ok = 1'b0;
  logic [3:0] strap_pin_i = 4'h0;
  logic [7:0] cfg_byte0 = 8'h00;
  logic [3:0] pad_oe;
  logic done, strap_mode, pci_div3, center_spread, code_rsvd;
  logic [2:0] strap_fs, eff_code;
  logic [10:0] cpu_freq_x10;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  strap_seq #(.WIN_CYCLES(WIN)) dut_i (
    .clk(clk), .supply_ok(supply_ok), .strap_pin_i(strap_pin_i), .cfg_byte0(cfg_byte0),
    .pad_oe(pad_oe), .done(done), .strap_fs(strap_fs), .strap_mode(strap_mode),
    .eff_code(eff_code), .cpu_freq_x10(cpu_freq_x10), .pci_div3(pci_div3),
    .center_spread(center_spread), .code_rsvd(code_rsvd));

  function automatic int exp_freq(input logic [2:0] c);
    case (c)
      3'd0: return 1240;
      3'd1, 3'd3: return 668;
      3'd2: return 833;
      3'd4: return 1030;
      3'd6: return 0;
      default: return 1000;
    endcase
  endfunction

  function automatic logic exp_div3(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd4 || c == 3'd5 || c == 3'd7);
  endfunction

  function automatic logic exp_center(input logic [2:0] c);
    return (c == 3'd1 || c == 3'd5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_decode(input logic [3:0] strap, input logic [7:0] cfg);
    logic [2:0] c;
    c = cfg[3] ? cfg[6:4] : strap[2:0];
    chk("R5 eff_code", 32'(eff_code), 32'(c));
    chk("R6 cpu_freq", 32'(cpu_freq_x10), 32'(exp_freq(c)));
    chk("R6 code_rsvd", 32'(code_rsvd), 32'(c == 3'd6));
    chk("R7 pci_div3", 32'(pci_div3), 32'(exp_div3(c)));
    chk("R7 center", 32'(center_spread), 32'(exp_center(c)));
  endtask

  task automatic power_up(input logic [3:0] early, input logic [3:0] final_lvl);
    supply_ok = 1'b0;
    strap_pin_i = early;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (WIN - 1) @(negedge clk);
    chk("R1 done low before end", 32'(done), 32'd0);
    chk("R1 oe low before end", 32'(pad_oe), 32'h0);
    strap_pin_i = final_lvl;
    @(negedge clk);
    chk("R1 done at end", 32'(done), 32'd1);
    chk("R1 oe at end", 32'(pad_oe), 32'hF);
    chk("R2 captured", 32'({strap_mode, strap_fs}), 32'(final_lvl));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    chk("R4 reset done", 32'(done), 32'd0);
    chk("R4 reset oe", 32'(pad_oe), 32'h0);
    chk("R4 reset strap", 32'({strap_mode, strap_fs}), 32'h0);

    // R2: the levels differ until one edge before capture
    power_up(4'b0110, 4'b1101);
    // R3: later pin and configuration changes have no effect
    strap_pin_i = 4'b0010;
    cfg_byte0 = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R3 hold after pin change", 32'({strap_mode, strap_fs}), 32'hD);
    chk("R1 stays on", 32'(pad_oe), 32'hF);
    cfg_byte0 = 8'h00;
    @(negedge clk);
    chk_decode(4'b1101, 8'h00);

    // R4: power off clears at once
    supply_ok = 1'b0;
    #1;
    chk("R4 off done", 32'(done), 32'd0);
    chk("R4 off strap", 32'({strap_mode, strap_fs}), 32'h0);

    // R4: abort partway through the window, then restart
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (WIN / 2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    power_up(4'b0000, 4'b1010);

    // R5, R6, R7: every code through both paths
    for (int c = 0; c < 8; c++) begin
      cfg_byte0 = {1'b0, 3'(c), 1'b1, 3'b000};
      @(negedge clk);
      chk_decode(4'b1010, cfg_byte0);
    end
    for (int c = 0; c < 8; c++) begin
      power_up(4'($urandom), {1'b0, 3'(c)});
      cfg_byte0 = 8'($urandom) & 8'hF7;
      @(negedge clk);
      chk_decode({1'b0, 3'(c)}, cfg_byte0);
    end
    for (int i = 0; i < 30; i++) begin
      logic [3:0] s;
      s = 4'($urandom);
      power_up(4'($urandom), s);
      cfg_byte0 = 8'($urandom);
      strap_pin_i = 4'($urandom);
      @(negedge clk);
      chk("R3 hold random", 32'({strap_mode, strap_fs}), 32'(s));
      chk_decode(s, cfg_byte0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule